// File: doc/BRIEF.md
# Dual-Page FIR Coefficient Store

This block keeps the tap coefficients of an N-tap FIR filter in two pages. The filter reads only from the active page, through a registered random-access port. A new set of coefficients is built in the other page, the shadow page, without disturbing the taps that are in use. The shadow page is filled in one of two ways. In serial-load mode each word arrives on a coefficient input with a valid strobe. In table mode a whole set is copied, one word per clock, from a bank of built-in constant tables chosen by a 4-bit selector. A third, fixed mode holds a single built-in set and ignores every page-control input.

The block raises a ready flag once the shadow page holds a complete set. A separate swap pulse then makes that page active. The swap is only accepted while the flag is high, so the filter never runs from a half-written page. The `MODE` parameter selects fixed (0), table (1) or serial-load (2) operation. `NUM_TAPS`, `COEF_W` and `NUM_SETS` size the storage.

Top module: `fir_coef_pages`

## Requirements
- R1: After the asynchronous reset `rst_n` is released, page 0 is active and `done_o` is low. In fixed and table mode, page 0 holds table set 0. In serial-load mode it holds zeros.
- R2: `rd_coef_o` shows the active-page word at the tap index that `rd_addr_i` held at the previous rising edge.
- R3: In serial-load mode a refresh pulse restarts the fill at tap 0. After that, each rising edge with `coef_valid_i` high writes `coef_i` to the next shadow tap. A strobe is ignored when it comes before any refresh, after the page is full, or in the same cycle as a refresh.
- R4: In serial-load mode, `done_o` goes high on the edge that writes the last tap, and not before.
- R5: In table mode, a refresh sampled at edge k copies one word per clock into the shadow page. `done_o` stays low after edges k+1 to k+N-1 and is high after edge k+N.
- R6: Word t of table set s is ((s+1)*29 + t*13 + s*t*7) mod 2^COEF_W. The set is latched at the refresh edge. A selector value of `NUM_SETS` or more copies set 0.
- R7: A swap pulse sampled while `done_o` is high exchanges the two pages on that edge and clears `done_o`. Reads issued after that edge return the newly filled set.
- R8: A swap pulse sampled while `done_o` is low has no effect on which page is active.
- R9: A refresh clears `done_o` on its edge and restarts the fill from tap 0, even in the middle of a fill.
- R10: In fixed mode, refresh, selector, swap and coefficient strobes are ignored. `done_o` stays low and reads always return set 0.
- R11: The synchronous reset `srst_n`, when low at a rising edge, returns the block to the same state as R1.
- R12: Fill writes never change the active page. Reads made during a fill return the old set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| srst_n | input | 1 | Synchronous reset, active low |
| refresh_i | input | 1 | Start a new shadow-page fill |
| set_sel_i | input | 4 | Table set to copy (table mode) |
| swap_i | input | 1 | Exchange active and shadow pages |
| coef_i | input | COEF_W | Serial coefficient word |
| coef_valid_i | input | 1 | Strobe for `coef_i` |
| rd_addr_i | input | $clog2(NUM_TAPS) | Tap index to read |
| rd_coef_o | output | COEF_W | Registered active-page word |
| done_o | output | 1 | Shadow page complete and ready to swap |

## Verification
Some rules are checked by assertions on every cycle:
- fill writes go only to the shadow page;
- a swap with the flag low leaves the active page alone, and a swap with the flag high flips it and clears the flag;
- a refresh clears the flag;
- the flag holds until a refresh or a swap;
- the flag rises only right after the last tap is written;
- fixed mode stays idle.

Other behaviour can only be shown by the bench's scenarios, which compare read data against an independent model:
- the words that end up in the pages;
- the exact table values and the clamping of out-of-range selectors;
- the N-cycle copy timing;
- strobes being dropped before a refresh, after the page is full, or in the refresh cycle;
- the sync-reset contents.

// File: rtl/fir_coef_pkg.sv
package fir_coef_pkg;

    localparam int MODE_FIXED  = 0;
    localparam int MODE_TABLE  = 1;
    localparam int MODE_SERIAL = 2;

    typedef enum logic [1:0] {
        FILL_IDLE   = 2'd0,
        FILL_SERIAL = 2'd1,
        FILL_COPY   = 2'd2
    } fill_state_e;

    // Built-in table word for set s, tap t (caller truncates to coefficient width)
    function automatic logic [31:0] table_word(input int unsigned s, input int unsigned t);
        table_word = 32'((s + 1) * 29 + t * 13 + s * t * 7);
    endfunction

endpackage

// File: rtl/fir_coef_rom.sv
module fir_coef_rom #(
    parameter int NUM_SETS = 4,
    parameter int NUM_TAPS = 8,
    parameter int COEF_W   = 16,
    parameter int ADDR_W   = (NUM_TAPS > 1) ? $clog2(NUM_TAPS) : 1,
    parameter int SET_W    = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
    input  logic [SET_W-1:0]  set_i,
    input  logic [ADDR_W-1:0] tap_i,
    output logic [COEF_W-1:0] data_o
);
    logic [COEF_W-1:0] rom [NUM_SETS][NUM_TAPS];

    for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
        for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
            assign rom[s][t] = COEF_W'(fir_coef_pkg::table_word(s, t));
        end
    end

    assign data_o = rom[set_i][tap_i];
endmodule

// File: rtl/fir_coef_bank.sv
module fir_coef_bank #(
    parameter int NUM_TAPS = 8,
    parameter int COEF_W   = 16,
    parameter int MODE     = fir_coef_pkg::MODE_TABLE,
    parameter int ADDR_W   = (NUM_TAPS > 1) ? $clog2(NUM_TAPS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              srst_n,
    input  logic              wr_en_i,
    input  logic              wr_page_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [COEF_W-1:0] wr_data_i,
    input  logic              rd_page_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [COEF_W-1:0] rd_data_o
);
    logic [COEF_W-1:0] pages_d [2][NUM_TAPS];
    logic [COEF_W-1:0] pages_q [2][NUM_TAPS];

    function automatic logic [COEF_W-1:0] reset_word(input int t);
        if (MODE == fir_coef_pkg::MODE_SERIAL) return '0;
        return COEF_W'(fir_coef_pkg::table_word(0, t));
    endfunction

    always_comb begin
        pages_d = pages_q;
        if (wr_en_i) begin
            pages_d[wr_page_i][wr_addr_i] = wr_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int p = 0; p < 2; p++) begin
                for (int t = 0; t < NUM_TAPS; t++) begin
                    pages_q[p][t] <= reset_word(t);
                end
            end
        end else if (!srst_n) begin
            for (int p = 0; p < 2; p++) begin
                for (int t = 0; t < NUM_TAPS; t++) begin
                    pages_q[p][t] <= reset_word(t);
                end
            end
        end else begin
            pages_q <= pages_d;
        end
    end

    assign rd_data_o = pages_q[rd_page_i][rd_addr_i];
endmodule

// File: rtl/fir_coef_fill_ctrl.sv
module fir_coef_fill_ctrl #(
    parameter int NUM_TAPS = 8,
    parameter int NUM_SETS = 4,
    parameter int MODE     = fir_coef_pkg::MODE_TABLE,
    parameter int ADDR_W   = (NUM_TAPS > 1) ? $clog2(NUM_TAPS) : 1,
    parameter int SET_W    = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              srst_n,
    input  logic              refresh_i,
    input  logic [3:0]        set_sel_i,
    input  logic              swap_i,
    input  logic              coef_valid_i,
    output logic              wr_en_o,
    output logic              wr_page_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [SET_W-1:0]  copy_set_o,
    output logic              done_o,
    output logic              active_o
);
    import fir_coef_pkg::*;

    localparam logic [ADDR_W-1:0] LAST_TAP = ADDR_W'(NUM_TAPS - 1);

    typedef struct packed {
        fill_state_e       fill;
        logic [ADDR_W-1:0] addr;
        logic [SET_W-1:0]  set;
        logic              done;
        logic              active;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{fill: FILL_IDLE, addr: '0, set: '0, done: 1'b0, active: 1'b0};

    ctrl_t st_d, st_q;
    logic  wr_en;

    always_comb begin
        st_d  = st_q;
        wr_en = 1'b0;
        if (MODE != MODE_FIXED) begin
            if (swap_i && st_q.done) begin
                st_d.active = ~st_q.active;
                st_d.done   = 1'b0;
            end
            if (refresh_i) begin
                st_d.addr = '0;
                st_d.done = 1'b0;
                st_d.fill = (MODE == MODE_SERIAL) ? FILL_SERIAL : FILL_COPY;
                st_d.set  = (int'(set_sel_i) < NUM_SETS) ? SET_W'(set_sel_i) : '0;
            end else begin
                unique case (st_q.fill)
                    FILL_SERIAL: wr_en = coef_valid_i;
                    FILL_COPY:   wr_en = 1'b1;
                    default:     wr_en = 1'b0;
                endcase
                if (wr_en) begin
                    if (st_q.addr == LAST_TAP) begin
                        st_d.fill = FILL_IDLE;
                        st_d.done = 1'b1;
                    end else begin
                        st_d.addr = st_q.addr + 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= CTRL_RST;
        end else if (!srst_n) begin
            st_q <= CTRL_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_en_o    = wr_en;
    assign wr_page_o  = ~st_q.active;
    assign wr_addr_o  = st_q.addr;
    assign copy_set_o = st_q.set;
    assign done_o     = st_q.done;
    assign active_o   = st_q.active;
endmodule

// File: rtl/fir_coef_rdport.sv
module fir_coef_rdport #(
    parameter int COEF_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              srst_n,
    input  logic [COEF_W-1:0] word_i,
    output logic [COEF_W-1:0] rd_coef_o
);
    typedef struct packed {
        logic [COEF_W-1:0] data;
    } rd_t;

    rd_t rd_d, rd_q;

    always_comb begin
        rd_d      = rd_q;
        rd_d.data = word_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (!srst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rd_coef_o = rd_q.data;
endmodule

// File: rtl/fir_coef_pages.sv
module fir_coef_pages #(
    parameter int NUM_TAPS = 8,
    parameter int COEF_W   = 16,
    parameter int NUM_SETS = 4,
    parameter int MODE     = fir_coef_pkg::MODE_TABLE,
    parameter int ADDR_W   = (NUM_TAPS > 1) ? $clog2(NUM_TAPS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              srst_n,
    input  logic              refresh_i,
    input  logic [3:0]        set_sel_i,
    input  logic              swap_i,
    input  logic [COEF_W-1:0] coef_i,
    input  logic              coef_valid_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [COEF_W-1:0] rd_coef_o,
    output logic              done_o
);
    localparam int SET_W = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1;

    logic              wr_en;
    logic              wr_page;
    logic [ADDR_W-1:0] wr_addr;
    logic [SET_W-1:0]  copy_set;
    logic              active_pg;
    logic [COEF_W-1:0] rom_word;
    logic [COEF_W-1:0] wr_data;
    logic [COEF_W-1:0] act_word;

    fir_coef_fill_ctrl #(
        .NUM_TAPS(NUM_TAPS), .NUM_SETS(NUM_SETS), .MODE(MODE),
        .ADDR_W(ADDR_W), .SET_W(SET_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .srst_n(srst_n),
        .refresh_i(refresh_i), .set_sel_i(set_sel_i), .swap_i(swap_i),
        .coef_valid_i(coef_valid_i),
        .wr_en_o(wr_en), .wr_page_o(wr_page), .wr_addr_o(wr_addr),
        .copy_set_o(copy_set), .done_o(done_o), .active_o(active_pg)
    );

    fir_coef_rom #(
        .NUM_SETS(NUM_SETS), .NUM_TAPS(NUM_TAPS), .COEF_W(COEF_W),
        .ADDR_W(ADDR_W), .SET_W(SET_W)
    ) u_rom (
        .set_i(copy_set), .tap_i(wr_addr), .data_o(rom_word)
    );

    if (MODE == fir_coef_pkg::MODE_SERIAL) begin : g_serial_src
        assign wr_data = coef_i;
    end else begin : g_table_src
        assign wr_data = rom_word;
    end

    fir_coef_bank #(
        .NUM_TAPS(NUM_TAPS), .COEF_W(COEF_W), .MODE(MODE), .ADDR_W(ADDR_W)
    ) u_bank (
        .clk(clk), .rst_n(rst_n), .srst_n(srst_n),
        .wr_en_i(wr_en), .wr_page_i(wr_page), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data),
        .rd_page_i(active_pg), .rd_addr_i(rd_addr_i), .rd_data_o(act_word)
    );

    fir_coef_rdport #(
        .COEF_W(COEF_W)
    ) u_rd (
        .clk(clk), .rst_n(rst_n), .srst_n(srst_n),
        .word_i(act_word), .rd_coef_o(rd_coef_o)
    );
endmodule

// File: rtl/fir_coef_pages_chk.sv
module fir_coef_pages_chk #(
    parameter int NUM_TAPS = 8,
    parameter int MODE     = fir_coef_pkg::MODE_TABLE,
    parameter int ADDR_W   = (NUM_TAPS > 1) ? $clog2(NUM_TAPS) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              srst_n,
    input logic              refresh_i,
    input logic              swap_i,
    input logic              done_o,
    input logic              active_pg,
    input logic              wr_en,
    input logic              wr_page,
    input logic [ADDR_W-1:0] wr_addr
);
    localparam logic [ADDR_W-1:0] LAST_TAP = ADDR_W'(NUM_TAPS - 1);

    // R12: fill writes land only in the shadow page
    assert_write_shadow_R12: assert property (@(posedge clk) disable iff (!rst_n || !srst_n)
        wr_en |-> (wr_page != active_pg));

    // R8: swap with flag low keeps the active page
    assert_swap_gated_R8: assert property (@(posedge clk) disable iff (!rst_n || !srst_n)
        (swap_i && !done_o) |=> $stable(active_pg));

    // R7: swap with flag high flips the page and clears the flag
    assert_swap_flip_R7: assert property (@(posedge clk) disable iff (!rst_n || !srst_n)
        (swap_i && done_o) |=> (active_pg != $past(active_pg)) && !done_o);

    // R9: refresh drops the ready flag
    assert_refresh_clear_R9: assert property (@(posedge clk) disable iff (!rst_n || !srst_n)
        refresh_i |=> !done_o);

    // R4: the flag persists until refresh or swap
    assert_done_hold_R4: assert property (@(posedge clk) disable iff (!rst_n || !srst_n)
        (done_o && !refresh_i && !swap_i) |=> done_o);

    // R5: the flag rises only right after the last tap is written
    assert_done_rise_R5: assert property (@(posedge clk) disable iff (!rst_n || !srst_n)
        $rose(done_o) |-> $past(wr_en && (wr_addr == LAST_TAP)));

    // R10: fixed mode stays idle
    assert_fixed_idle_R10: assert property (@(posedge clk) disable iff (!rst_n || !srst_n)
        (MODE == fir_coef_pkg::MODE_FIXED) |-> (!done_o && !wr_en && !active_pg));
endmodule

bind fir_coef_pages fir_coef_pages_chk #(
    .NUM_TAPS(NUM_TAPS), .MODE(MODE), .ADDR_W(ADDR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .srst_n(srst_n),
    .refresh_i(refresh_i), .swap_i(swap_i), .done_o(done_o),
    .active_pg(active_pg), .wr_en(wr_en), .wr_page(wr_page), .wr_addr(wr_addr)
);

// File: tb/fir_coef_pages_tb.sv
`timescale 1ns/1ps
module fir_coef_pages_tb;
    import fir_coef_pkg::*;

    localparam int N  = 8;
    localparam int W  = 16;
    localparam int NS = 4;
    localparam int AW = $clog2(N);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic srst_n = 1'b1;
    logic refresh = 1'b0;
    logic [3:0] sel = '0;
    logic swap = 1'b0;
    logic [W-1:0] coef = '0;
    logic cvalid = 1'b0;
    logic [AW-1:0] rd_addr = '0;

    logic [W-1:0] rd_o [3];
    logic         done_w [3];

    int checks = 0;
    int errors = 0;
    string phase = "R1";
    bit ended = 0;

    always #2.5 clk = ~clk;

    fir_coef_pages #(.NUM_TAPS(N), .COEF_W(W), .NUM_SETS(NS), .MODE(MODE_FIXED)) u_dut_cst (
        .clk(clk), .rst_n(rst_n), .srst_n(srst_n), .refresh_i(refresh), .set_sel_i(sel),
        .swap_i(swap), .coef_i(coef), .coef_valid_i(cvalid), .rd_addr_i(rd_addr),
        .rd_coef_o(rd_o[0]), .done_o(done_w[0]));
    fir_coef_pages #(.NUM_TAPS(N), .COEF_W(W), .NUM_SETS(NS), .MODE(MODE_TABLE)) u_dut (
        .clk(clk), .rst_n(rst_n), .srst_n(srst_n), .refresh_i(refresh), .set_sel_i(sel),
        .swap_i(swap), .coef_i(coef), .coef_valid_i(cvalid), .rd_addr_i(rd_addr),
        .rd_coef_o(rd_o[1]), .done_o(done_w[1]));
    fir_coef_pages #(.NUM_TAPS(N), .COEF_W(W), .NUM_SETS(NS), .MODE(MODE_SERIAL)) u_dut_rl (
        .clk(clk), .rst_n(rst_n), .srst_n(srst_n), .refresh_i(refresh), .set_sel_i(sel),
        .swap_i(swap), .coef_i(coef), .coef_valid_i(cvalid), .rd_addr_i(rd_addr),
        .rd_coef_o(rd_o[2]), .done_o(done_w[2]));

    function automatic logic [W-1:0] tab(input int s, input int t);
        return W'((s + 1) * 29 + t * 13 + s * t * 7);
    endfunction

    // Independent expected-value model, one per mode (0 fixed, 1 table, 2 serial)
    logic [W-1:0] mp [3][2][N];
    logic         mact [3];
    logic         mdone [3];
    logic         mbusy [3];
    int           maddr [3];
    int           mset [3];
    logic [W-1:0] mrd [3];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n || !srst_n) begin
            for (int m = 0; m < 3; m++) begin
                for (int p = 0; p < 2; p++)
                    for (int t = 0; t < N; t++)
                        mp[m][p][t] <= (m == 2) ? '0 : tab(0, t);
                mact[m] <= 1'b0; mdone[m] <= 1'b0; mbusy[m] <= 1'b0;
                maddr[m] <= 0; mset[m] <= 0; mrd[m] <= '0;
            end
        end else begin
            for (int m = 0; m < 3; m++) begin
                mrd[m] <= mp[m][mact[m]][rd_addr];
                if (m != 0) begin
                    if (swap && mdone[m]) begin
                        mact[m] <= !mact[m];
                        mdone[m] <= 1'b0;
                    end
                    if (refresh) begin
                        mbusy[m] <= 1'b1; maddr[m] <= 0; mdone[m] <= 1'b0;
                        mset[m] <= (int'(sel) < NS) ? int'(sel) : 0;
                    end else if (mbusy[m] && (m == 1 || cvalid)) begin
                        mp[m][!mact[m]][maddr[m]] <= (m == 2) ? coef : tab(mset[m], maddr[m]);
                        if (maddr[m] == N - 1) begin
                            mbusy[m] <= 1'b0; mdone[m] <= 1'b1;
                        end else begin
                            maddr[m] <= maddr[m] + 1;
                        end
                    end
                end
            end
        end
    end

    task automatic check(input string tag, input int m, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s mode %0d: actual %0d expected %0d at %0t", tag, m, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        for (int m = 0; m < 3; m++) begin
            check(phase, m, 32'(rd_o[m]), 32'(mrd[m]));
            check(phase, m, 32'(done_w[m]), 32'(mdone[m]));
        end
    endtask

    task automatic cycle(input logic r, input logic [3:0] s, input logic sw,
                         input logic v, input logic [W-1:0] c, input int a);
        refresh = r; sel = s; swap = sw; cvalid = v; coef = c; rd_addr = AW'(a);
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle(input int a);
        cycle(1'b0, 4'd0, 1'b0, 1'b0, '0, a);
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hang, expected end of run");
        finish_run();
    end

    initial begin
        void'($urandom(32'hC0EF_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset contents and flag
        phase = "R1";
        for (int t = 0; t < N; t++) begin
            idle(t);
            for (int m = 0; m < 3; m++) begin
                check("R1", m, 32'(rd_o[m]), (m == 2) ? 32'd0 : 32'(tab(0, t)));
                check("R1", m, 32'(done_w[m]), 32'd0);
            end
        end

        // R8 / R12: partial fill of set 2, early swap ignored, reads keep set 0
        phase = "R8";
        cycle(1'b1, 4'd2, 1'b0, 1'b0, '0, 0);
        repeat (3) idle(0);
        cycle(1'b0, 4'd0, 1'b1, 1'b0, '0, 0);
        for (int t = 0; t < N; t++) begin
            idle(t);
            check("R8", 1, 32'(rd_o[1]), 32'(tab(0, t)));
            check("R12", 2, 32'(rd_o[2]), 32'd0);
        end
        check("R5", 1, 32'(done_w[1]), 32'd1);

        // R7: swap with flag high, reads see set 2
        phase = "R7";
        cycle(1'b0, 4'd0, 1'b1, 1'b0, '0, 0);
        check("R7", 1, 32'(done_w[1]), 32'd0);
        for (int t = 0; t < N; t++) begin
            idle(t);
            check("R7", 1, 32'(rd_o[1]), 32'(tab(2, t)));
        end

        // R5 / R6: copy timing, out-of-range selector clamps to set 0
        phase = "R5";
        cycle(1'b1, 4'd13, 1'b0, 1'b0, '0, 0);
        for (int i = 1; i <= N; i++) begin
            idle(0);
            check("R5", 1, 32'(done_w[1]), (i == N) ? 32'd1 : 32'd0);
        end
        phase = "R6";
        cycle(1'b0, 4'd0, 1'b1, 1'b0, '0, 0);
        for (int t = 0; t < N; t++) begin
            idle(t);
            check("R6", 1, 32'(rd_o[1]), 32'(tab(0, t)));
        end
        cycle(1'b1, 4'd3, 1'b0, 1'b0, '0, 0);
        repeat (N) idle(0);
        cycle(1'b0, 4'd0, 1'b1, 1'b0, '0, 0);
        for (int t = 0; t < N; t++) begin
            idle(t);
            check("R6", 1, 32'(rd_o[1]), 32'(tab(3, t)));
        end

        // R3 / R4: serial load, strobe in refresh cycle and after full ignored
        phase = "R3";
        cycle(1'b1, 4'd0, 1'b0, 1'b1, W'(555), 0);
        for (int i = 1; i <= N; i++) begin
            cycle(1'b0, 4'd0, 1'b0, 1'b1, W'(100 + i - 1), 0);
            check("R4", 2, 32'(done_w[2]), (i == N) ? 32'd1 : 32'd0);
            if (i == 3) idle(0);
        end
        repeat (2) cycle(1'b0, 4'd0, 1'b0, 1'b1, W'(999), 0);
        cycle(1'b0, 4'd0, 1'b1, 1'b0, '0, 0);
        for (int t = 0; t < N; t++) begin
            idle(t);
            check("R3", 2, 32'(rd_o[2]), 32'(100 + t));
        end

        // R9: restart mid fill, and refresh clears a raised flag
        phase = "R9";
        cycle(1'b1, 4'd0, 1'b0, 1'b0, '0, 0);
        repeat (3) cycle(1'b0, 4'd0, 1'b0, 1'b1, W'(777), 0);
        cycle(1'b1, 4'd0, 1'b0, 1'b0, '0, 0);
        for (int i = 0; i < N; i++) cycle(1'b0, 4'd0, 1'b0, 1'b1, W'(200 + i), 0);
        check("R9", 2, 32'(done_w[2]), 32'd1);
        cycle(1'b0, 4'd0, 1'b1, 1'b0, '0, 0);
        for (int t = 0; t < N; t++) begin
            idle(t);
            check("R9", 2, 32'(rd_o[2]), 32'(200 + t));
        end
        cycle(1'b1, 4'd1, 1'b0, 1'b0, '0, 0);
        repeat (N) idle(0);
        check("R9", 1, 32'(done_w[1]), 32'd1);
        cycle(1'b1, 4'd1, 1'b0, 1'b0, '0, 0);
        check("R9", 1, 32'(done_w[1]), 32'd0);

        // R10: fixed mode ignores every control input
        phase = "R10";
        for (int t = 0; t < N; t++) begin
            cycle(1'b1, 4'd2, 1'b1, 1'b1, W'(321), t);
            idle(t);
            check("R10", 0, 32'(rd_o[0]), 32'(tab(0, t)));
            check("R10", 0, 32'(done_w[0]), 32'd0);
        end

        // R11: synchronous reset
        phase = "R11";
        repeat (N) idle(0);
        srst_n = 1'b0;
        idle(0);
        srst_n = 1'b1;
        for (int t = 0; t < N; t++) begin
            idle(t);
            check("R11", 1, 32'(rd_o[1]), 32'(tab(0, t)));
            check("R11", 2, 32'(rd_o[2]), 32'd0);
            check("R11", 1, 32'(done_w[1]), 32'd0);
        end

        // R2: constrained random traffic against the model
        phase = "R2";
        for (int i = 0; i < 3000; i++) begin
            cycle(($urandom % 16) == 0, 4'($urandom), ($urandom % 6) == 0,
                  ($urandom % 2) == 0, W'($urandom), int'($urandom % N));
        end

        finish_run();
    end
endmodule